// File: doc/BRIEF.md
# Cross-Coupled Processor Sync Mailbox

This block joins two processors through a pair of small sync registers, one register per processor port. Each side owns a 4-bit status nibble that it writes into its own register. The other side reads that nibble, read-only, in the low bits of its own register, so each CPU can publish a small state code that its partner polls.

Each side also has a doorbell. A write from one side with the doorbell bit set sends a one-cycle interrupt pulse toward the other CPU. The pulse is sent only if the receiving side has set its own doorbell-enable bit. The pulse output goes to the interrupt controller of the receiving processor, and that controller decides how the request is latched.

Both ports take full 32-bit writes with no byte lanes. Writes are registered, so a written value is visible at both read ports in the cycle after the write.

Top module: `xcpu_sync_mailbox`

## Requirements
- R1: After reset, both read outputs are 0x0000_0000 and both doorbell outputs are low.
- R2: A write stores write-data bits 11:8 (the outgoing nibble) and bit 14 (the doorbell enable). Every other bit of the write data has no effect. A port that is not written keeps its stored value.
- R3: A port's outgoing nibble (its bits 11:8) reads back in bits 3:0 of the other port's read data. It is visible in the cycle after the write.
- R4: Read data bits 31:15, 13, 12 and 7:4 always read as 0. The doorbell bit 13 is never stored.
- R5: A write with data bit 13 = 1, made while the other port's stored bit 14 is 1, drives that port's doorbell output high for exactly the cycle after the write.
- R6: A write with bit 13 = 1 while the other port's stored bit 14 is 0 produces no pulse. A write with bit 13 = 0 never produces a pulse.
- R7: When both ports write in the same cycle, each update, each mirror and each doorbell is applied independently. A doorbell is gated by the enable value the receiving port held before that cycle.
- R8: Doorbell writes on consecutive cycles give one pulse cycle per qualifying write. The output falls in the cycle after the last such write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr_en | input | 1 | Port A register write strobe |
| a_wr_data | input | 32 | Port A write data |
| a_rd_data | output | 32 | Port A register view |
| a_ring_peer | output | 1 | Doorbell pulse from A toward CPU B |
| b_wr_en | input | 1 | Port B register write strobe |
| b_wr_data | input | 32 | Port B write data |
| b_rd_data | output | 32 | Port B register view |
| b_ring_peer | output | 1 | Doorbell pulse from B toward CPU A |

## Verification
The assertions check four things on every cycle:
- the nibble mirror between the two read views;
- that the reserved and doorbell bits read as zero;
- that a stored register holds when it is not written;
- that every doorbell pulse traces back to a qualifying write made while the peer was enabled.

The bench's scenarios are needed for the rest:
- the exact values stored from write data that carries junk in the ignored bits;
- that pulses are absent when the peer is disabled;
- back-to-back pulse counts;
- simultaneous writes from both sides, where each doorbell must use the enable held before the cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int MBX_DATA_W   = 32;
  localparam int MBX_NIB_W    = 4;
  localparam int MBX_OUT_LSB  = 8;
  localparam int MBX_BELL_BIT = 13;
  localparam int MBX_EN_BIT   = 14;

  // Mask of the bits a write stores: the outgoing nibble and the enable.
  function automatic logic [MBX_DATA_W-1:0] keep_mask(input int nib_w, input int out_lsb,
                                                      input int en_bit);
    logic [MBX_DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < nib_w; i++) m[out_lsb+i] = 1'b1;
    m[en_bit] = 1'b1;
    return m;
  endfunction

  // Merge write data into the stored register under the keep mask.
  function automatic logic [MBX_DATA_W-1:0] merge_write(input logic [MBX_DATA_W-1:0] old_v,
                                                        input logic [MBX_DATA_W-1:0] wdata,
                                                        input logic [MBX_DATA_W-1:0] keep);
    return (wdata & keep) | (old_v & ~keep);
  endfunction

  // The read view: own stored fields, plus the peer's nibble shifted into the low bits.
  function automatic logic [MBX_DATA_W-1:0] read_view(input logic [MBX_DATA_W-1:0] own_v,
                                                      input logic [MBX_DATA_W-1:0] peer_v,
                                                      input logic [MBX_DATA_W-1:0] keep,
                                                      input int nib_w, input int out_lsb);
    logic [MBX_DATA_W-1:0] nib_m;
    nib_m = (MBX_DATA_W'(1) << nib_w) - MBX_DATA_W'(1);
    return (own_v & keep) | ((peer_v >> out_lsb) & nib_m);
  endfunction

endpackage

// File: rtl/mbx_port_state.sv
module mbx_port_state
  import mbx_pkg::*;
#(
  parameter int DATA_W  = MBX_DATA_W,
  parameter int NIB_W   = MBX_NIB_W,
  parameter int OUT_LSB = MBX_OUT_LSB,
  parameter int EN_BIT  = MBX_EN_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] reg_q,
  output logic              bell_en
);

  localparam logic [DATA_W-1:0] KEEP = keep_mask(NIB_W, OUT_LSB, EN_BIT);

  logic [DATA_W-1:0] reg_d;

  always_comb begin
    reg_d = reg_q;
    if (wr_en) reg_d = merge_write(reg_q, wr_data, KEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_q <= '0;
    else        reg_q <= reg_d;
  end

  assign bell_en = reg_q[EN_BIT];

  // R2: an unwritten register holds its value
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_q));

  // R4: bits outside the nibble and the enable are never stored
  assert_reserved_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_q & ~KEEP) == '0);

endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic bell_bit,
  input  logic peer_en,
  output logic ring
);

  logic fire;

  assign fire = wr_en & bell_bit & peer_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring <= 1'b0;
    else        ring <= fire;
  end

  // R6: no pulse unless the peer was enabled at the write
  assert_no_ring_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ring |-> $past(peer_en));

  // R8: a pulse lasts one cycle unless another qualifying write followed
  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ring && !fire |=> !ring);

endmodule

// File: rtl/xcpu_sync_mailbox.sv
module xcpu_sync_mailbox
  import mbx_pkg::*;
#(
  parameter int NIB_W    = MBX_NIB_W,
  parameter int OUT_LSB  = MBX_OUT_LSB,
  parameter int BELL_BIT = MBX_BELL_BIT,
  parameter int EN_BIT   = MBX_EN_BIT
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        a_wr_en,
  input  logic [31:0] a_wr_data,
  output logic [31:0] a_rd_data,
  output logic        a_ring_peer,
  input  logic        b_wr_en,
  input  logic [31:0] b_wr_data,
  output logic [31:0] b_rd_data,
  output logic        b_ring_peer
);

  localparam int DATA_W = MBX_DATA_W;
  localparam int NPORT  = 2;
  localparam logic [DATA_W-1:0] KEEP = keep_mask(NIB_W, OUT_LSB, EN_BIT);

  logic [NPORT-1:0]             wr_en;
  logic [NPORT-1:0][DATA_W-1:0] wr_data;
  logic [NPORT-1:0][DATA_W-1:0] reg_q;
  logic [NPORT-1:0][DATA_W-1:0] view;
  logic [NPORT-1:0]             bell_en;
  logic [NPORT-1:0]             ring;

  assign wr_en   = {b_wr_en, a_wr_en};
  assign wr_data = {b_wr_data, a_wr_data};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mbx_port_state #(
      .DATA_W (DATA_W),
      .NIB_W  (NIB_W),
      .OUT_LSB(OUT_LSB),
      .EN_BIT (EN_BIT)
    ) u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en[p]),
      .wr_data(wr_data[p]),
      .reg_q  (reg_q[p]),
      .bell_en(bell_en[p])
    );

    mbx_doorbell u_bell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en[p]),
      .bell_bit(wr_data[p][BELL_BIT]),
      .peer_en (bell_en[NPORT-1-p]),
      .ring    (ring[p])
    );

    assign view[p] = read_view(reg_q[p], reg_q[NPORT-1-p], KEEP, NIB_W, OUT_LSB);
  end

  assign a_rd_data   = view[0];
  assign b_rd_data   = view[1];
  assign a_ring_peer = ring[0];
  assign b_ring_peer = ring[1];

  // R3: each port's outgoing nibble shows in the peer's low bits
  assert_mirror_ab_R3: assert property (@(posedge clk) disable iff (!rst_n)
    a_rd_data[NIB_W-1:0] == b_rd_data[OUT_LSB +: NIB_W]);
  assert_mirror_ba_R3: assert property (@(posedge clk) disable iff (!rst_n)
    b_rd_data[NIB_W-1:0] == a_rd_data[OUT_LSB +: NIB_W]);

  // R4: the doorbell bit never reads back
  assert_bell_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rd_data[BELL_BIT] && !b_rd_data[BELL_BIT]);

  // R5: a pulse toward B follows a bell write from A while B was enabled
  assert_ring_cause_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    a_ring_peer |-> $past(a_wr_en && a_wr_data[BELL_BIT] && b_rd_data[EN_BIT]));
  assert_ring_cause_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    b_ring_peer |-> $past(b_wr_en && b_wr_data[BELL_BIT] && a_rd_data[EN_BIT]));

endmodule

// File: tb/xcpu_sync_mailbox_test.sv
`timescale 1ns/1ps
module xcpu_sync_mailbox_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_wr_en = 1'b0, b_wr_en = 1'b0;
  logic [31:0] a_wr_data = '0, b_wr_data = '0;
  logic [31:0] a_rd_data, b_rd_data;
  logic        a_ring_peer, b_ring_peer;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench model of the stored fields
  logic [3:0] m_nib [2];
  logic       m_en  [2];
  logic       m_ring[2];

  always #2 clk = ~clk;

  xcpu_sync_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .a_wr_en(a_wr_en), .a_wr_data(a_wr_data), .a_rd_data(a_rd_data), .a_ring_peer(a_ring_peer),
    .b_wr_en(b_wr_en), .b_wr_data(b_wr_data), .b_rd_data(b_rd_data), .b_ring_peer(b_ring_peer)
  );

  function automatic logic [31:0] exp_view(input int p);
    return 32'(m_en[p]) * 32'd16384 + 32'(m_nib[p]) * 32'd256 + 32'(m_nib[1-p]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] junk_word(input int s, input logic [3:0] nib,
                                            input logic en, input logic bell);
    logic [31:0] j;
    j = (32'hA5C3_90F6 ^ (32'(s) * 32'h0101_0107)) & ~32'h0000_6F00;
    return j | (32'(nib) << 8) | (32'(en) << 14) | (32'(bell) << 13);
  endfunction

  // One clock cycle with optional writes on each port, then the model update and the checks
  task automatic cycle(input string tag, input logic aw, input logic [31:0] ad,
                       input logic bw, input logic [31:0] bd);
    logic old_en_a, old_en_b;
    a_wr_en = aw; a_wr_data = ad;
    b_wr_en = bw; b_wr_data = bd;
    @(posedge clk); #1;
    old_en_a = m_en[0]; old_en_b = m_en[1];
    m_ring[0] = aw && ad[13] && old_en_b;
    m_ring[1] = bw && bd[13] && old_en_a;
    if (aw) begin m_nib[0] = ad[11:8]; m_en[0] = ad[14]; end
    if (bw) begin m_nib[1] = bd[11:8]; m_en[1] = bd[14]; end
    a_wr_en = 1'b0; b_wr_en = 1'b0;
    chk({tag, " R2 R3 R4 view A"}, a_rd_data, exp_view(0));
    chk({tag, " R2 R3 R4 view B"}, b_rd_data, exp_view(1));
    chk({tag, " R5 R6 R8 ring A"}, {31'd0, a_ring_peer}, {31'd0, m_ring[0]});
    chk({tag, " R5 R6 R8 ring B"}, {31'd0, b_ring_peer}, {31'd0, m_ring[1]});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 2; p++) begin m_nib[p] = '0; m_en[p] = 1'b0; m_ring[p] = 1'b0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1 reset view A", a_rd_data, 32'h0);
    chk("R1 reset view B", b_rd_data, 32'h0);
    chk("R1 reset rings", {30'd0, a_ring_peer, b_ring_peer}, 32'h0);
    rst_n = 1'b1;
    cycle("R1 idle", 1'b0, '0, 1'b0, '0);

    // R2 R3 R4: every nibble and enable from each side, with junk in the ignored bits
    for (int n = 0; n < 16; n++)
      for (int e = 0; e < 2; e++) begin
        cycle("sweepA", 1'b1, junk_word(n * 2 + e, 4'(n), e[0], 1'b0), 1'b0, '0);
        cycle("sweepB", 1'b0, '0, 1'b1, junk_word(n * 3 + e, 4'(15 - n), e[0], 1'b0));
        cycle("hold R2", 1'b0, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFF);
      end

    // R5 R6: doorbell from each side against each peer-enable value
    for (int s = 0; s < 2; s++)
      for (int pe = 0; pe < 2; pe++)
        for (int bl = 0; bl < 2; bl++) begin
          if (s == 0) begin
            cycle("peer en", 1'b0, '0, 1'b1, junk_word(pe, m_nib[1], pe[0], 1'b0));
            cycle("bell", 1'b1, junk_word(bl + 7, 4'(pe * 5 + bl), 1'b1, bl[0]), 1'b0, '0);
          end else begin
            cycle("peer en", 1'b1, junk_word(pe, m_nib[0], pe[0], 1'b0), 1'b0, '0);
            cycle("bell", 1'b0, '0, 1'b1, junk_word(bl + 9, 4'(pe * 3 + bl), 1'b1, bl[0]));
          end
          cycle("R8 after", 1'b0, '0, 1'b0, '0);
        end

    // R8: back-to-back doorbells give one pulse cycle each
    cycle("en both", 1'b1, junk_word(1, 4'h3, 1'b1, 1'b0), 1'b1, junk_word(2, 4'hC, 1'b1, 1'b0));
    for (int k = 0; k < 3; k++)
      cycle("R8 burst", 1'b1, junk_word(k, 4'(k), 1'b1, 1'b1), 1'b0, '0);
    cycle("R8 tail", 1'b0, '0, 1'b0, '0);
    cycle("R8 tail2", 1'b0, '0, 1'b0, '0);

    // R7: simultaneous writes, enables toggled while bells fly
    for (int n = 0; n < 16; n++)
      for (int m = 0; m < 16; m++)
        cycle("R7 both", 1'b1, junk_word(n + m, 4'(n), m[0], n[1]),
              1'b1, junk_word(n * m, 4'(m), n[0], m[1]));
    cycle("R7 end", 1'b0, '0, 1'b0, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule